// File: doc/BRIEF.md
# Indexed Multi-Socket Register Port

This block is the host-facing register window of a bridge that serves up to four card sockets. The host sees only two byte-wide locations. Location 0 is an index latch. Location 1 is a data window that reads or writes the byte register the index currently points at. The index space is flat. Each socket owns a bank of 64 byte registers, and bank n starts at index n × 0x40. Upper index bits therefore pick the socket and the low six bits pick the register inside its bank.

A separate configuration write path loads two bytes. The first is a global configuration byte whose bits [2:1] set how many sockets are active. The second is an interrupt routing byte, with one bit per event class, that steers each class to the PCI interrupt (1) or the legacy interrupt (0). An index that falls in the bank of a socket beyond the active count decodes as absent. Such an access reads zero and writes nothing. Every data-window read of a present bank emits a one-cycle strobe tagged with the socket and the local register number. Neighbouring logic uses it to give registers side effects on read, such as read-to-clear status.

Top module: `sockport_top`

## Requirements
- R1: After reset the index latch holds 0x00. An index read (location 0) returns the last byte written to location 0.
- R2: A data-window access (location 1) acts on socket `index[7:6]`, local register `index[5:0]`. Each of the 4 × 64 byte registers stores its own value, and all of them reset to 0x00.
- R3: Data-window reads and writes never change the index. A read-modify-write (index write, data read, index write, data write) updates only the selected register.
- R4: `active_count` follows configuration bits [2:1]: 00 gives 2, 01 gives 1, 10 and 11 give 4. The other configuration bits have no effect. Reset configuration is 0x00, which gives 2.
- R5: A data access to a socket number at or above `active_count` reads 0x00, and its write is dropped. The register keeps its old value, which is visible once the socket is active again.
- R6: `rd_stb` is high for exactly one cycle after each data-window read of a present bank, with `rd_sock` and `rd_reg` equal to the decoded socket and local register. Index accesses, writes and absent-bank reads give no strobe.
- R7: `route_pci` shows the last routing byte written (cfg_target=1), one bit per event class (1 = PCI, 0 = legacy). It resets to 0x00, and configuration writes do not change it.
- R8: A 16-bit value is kept as two byte registers, low byte at index i and high byte at i+1, written by two separate index/data transactions. Writing one half leaves the other half unchanged.
- R9: When a configuration write and a data access fall in the same cycle, the access is gated by the socket count in force before that cycle's clock edge.
- R10: `host_rdata` is registered. It changes one clock after a read (index or data) and otherwise holds its value. It resets to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access valid this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 1 | 0 = index location, 1 = data location |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| cfg_we | input | 1 | Configuration-side write strobe |
| cfg_target | input | 1 | 0 = configuration byte, 1 = routing byte |
| cfg_wdata | input | 8 | Configuration-side write byte |
| active_count | output | 3 | Number of active sockets |
| route_pci | output | 8 | Interrupt routing, 1 = PCI per event class |
| rd_stb | output | 1 | One-cycle data-read strobe |
| rd_sock | output | 2 | Socket of the strobed read |
| rd_reg | output | 6 | Local register of the strobed read |

## Verification
A configuration write that changes the socket count can land in the same cycle as a host data access to a bank whose presence depends on that count. The bench provokes both directions. In one, it writes a bank of socket 2 while the count drops from four to two. In the other, it writes the same bank while the count rises from two to four. It then re-enables the socket and reads the register back. The first write must be kept and the second must be dropped, which shows that the gate uses the count held before the edge.

// File: rtl/sockport_pkg.sv
package sockport_pkg;

   typedef enum logic {
      LOC_INDEX = 1'b0,
      LOC_DATA  = 1'b1
   } host_loc_e;

   // socket-count field decode: 00 -> 2, 01 -> 1, 1x -> 4
   function automatic int unsigned count_from_field(input logic [1:0] fld);
      case (fld)
         2'b00:   return 2;
         2'b01:   return 1;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/sockport_index.sv
module sockport_index #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] idx_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) idx_q <= '0;
      else if (we) idx_q <= wdata;
   end

   // R1 / R3: index only moves on an index write
   a_r3_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(idx_q));

endmodule

// File: rtl/sockport_cfg.sv
module sockport_cfg #(
   parameter int DATA_W    = 8,
   parameter int MAX_SOCK  = 4,
   parameter int FIELD_LSB = 1,
   localparam int CNT_W    = $clog2(MAX_SOCK + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              target,
   input  logic [DATA_W-1:0] wdata,
   output logic [CNT_W-1:0]  count,
   output logic [DATA_W-1:0] route_q
);
   import sockport_pkg::*;

   logic [1:0]   fld_q;
   int unsigned  raw_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fld_q   <= 2'b00;
         route_q <= '0;
      end else if (we) begin
         if (target) route_q <= wdata;
         else        fld_q   <= wdata[FIELD_LSB +: 2];
      end
   end

   always_comb begin
      raw_cnt = count_from_field(fld_q);
      if (raw_cnt > MAX_SOCK) raw_cnt = MAX_SOCK;
      count = CNT_W'(raw_cnt);
   end

   // R4: count is always one of the legal values
   a_r4_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(1)) || (count == CNT_W'(2)) || (count == CNT_W'(MAX_SOCK < 4 ? MAX_SOCK : 4)));

   // R7: routing byte only changes on a routing write
   a_r7_route_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && target) |=> $stable(route_q));

endmodule

// File: rtl/sockport_decode.sv
module sockport_decode #(
   parameter int DATA_W     = 8,
   parameter int MAX_SOCK   = 4,
   parameter int BANK_DEPTH = 64,
   localparam int LOC_W     = $clog2(BANK_DEPTH),
   localparam int SOCK_W    = (MAX_SOCK > 1) ? $clog2(MAX_SOCK) : 1,
   localparam int CNT_W     = $clog2(MAX_SOCK + 1)
) (
   input  logic [DATA_W-1:0] idx,
   input  logic [CNT_W-1:0]  count,
   output logic [SOCK_W-1:0] sock,
   output logic [LOC_W-1:0]  loc,
   output logic              present
);

   logic in_range;

   assign loc  = idx[LOC_W-1:0];
   assign sock = idx[LOC_W +: SOCK_W];

   generate
      if (DATA_W > LOC_W + SOCK_W) begin : g_hi_bits
         assign in_range = (idx[DATA_W-1:LOC_W+SOCK_W] == '0);
      end else begin : g_no_hi
         assign in_range = 1'b1;
      end
   endgenerate

   assign present = in_range && ({{(CNT_W){1'b0}}, sock} < {{(SOCK_W){1'b0}}, count});

endmodule

// File: rtl/sockport_regfile.sv
module sockport_regfile #(
   parameter int DATA_W     = 8,
   parameter int MAX_SOCK   = 4,
   parameter int BANK_DEPTH = 64,
   localparam int LOC_W     = $clog2(BANK_DEPTH),
   localparam int SOCK_W    = (MAX_SOCK > 1) ? $clog2(MAX_SOCK) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SOCK_W-1:0] sock,
   input  logic [LOC_W-1:0]  loc,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] bank_rd [MAX_SOCK];

   generate
      for (genvar s = 0; s < MAX_SOCK; s++) begin : g_bank
         logic [DATA_W-1:0] mem [BANK_DEPTH];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int k = 0; k < BANK_DEPTH; k++) mem[k] <= '0;
            end else if (we && (sock == SOCK_W'(s))) begin
               mem[loc] <= wdata;
            end
         end
         assign bank_rd[s] = mem[loc];
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int s = 0; s < MAX_SOCK; s++)
         if (sock == SOCK_W'(s)) rdata = bank_rd[s];
   end

endmodule

// File: rtl/sockport_top.sv
module sockport_top #(
   parameter int DATA_W     = 8,
   parameter int MAX_SOCK   = 4,
   parameter int BANK_DEPTH = 64,
   localparam int LOC_W     = $clog2(BANK_DEPTH),
   localparam int SOCK_W    = (MAX_SOCK > 1) ? $clog2(MAX_SOCK) : 1,
   localparam int CNT_W     = $clog2(MAX_SOCK + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel,
   input  logic              host_wr,
   input  logic              host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              cfg_we,
   input  logic              cfg_target,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [CNT_W-1:0]  active_count,
   output logic [DATA_W-1:0] route_pci,
   output logic              rd_stb,
   output logic [SOCK_W-1:0] rd_sock,
   output logic [LOC_W-1:0]  rd_reg
);
   import sockport_pkg::*;

   initial begin
      if (MAX_SOCK * BANK_DEPTH > (1 << DATA_W))
         $error("sockport_top: banks do not fit in index space");
      if ((1 << LOC_W) != BANK_DEPTH)
         $error("sockport_top: BANK_DEPTH must be a power of two");
   end

   logic              idx_we, dat_we, dat_rd, any_rd;
   logic [DATA_W-1:0] idx_q, bank_byte;
   logic [SOCK_W-1:0] dec_sock;
   logic [LOC_W-1:0]  dec_loc;
   logic              dec_present;

   assign idx_we = host_sel &&  host_wr && (host_addr == LOC_INDEX);
   assign dat_we = host_sel &&  host_wr && (host_addr == LOC_DATA) && dec_present;
   assign dat_rd = host_sel && !host_wr && (host_addr == LOC_DATA);
   assign any_rd = host_sel && !host_wr;

   sockport_index #(.DATA_W(DATA_W)) u_index (
      .clk(clk), .rst_n(rst_n), .we(idx_we), .wdata(host_wdata), .idx_q(idx_q));

   sockport_cfg #(.DATA_W(DATA_W), .MAX_SOCK(MAX_SOCK)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .target(cfg_target),
      .wdata(cfg_wdata), .count(active_count), .route_q(route_pci));

   sockport_decode #(.DATA_W(DATA_W), .MAX_SOCK(MAX_SOCK), .BANK_DEPTH(BANK_DEPTH)) u_dec (
      .idx(idx_q), .count(active_count), .sock(dec_sock), .loc(dec_loc),
      .present(dec_present));

   sockport_regfile #(.DATA_W(DATA_W), .MAX_SOCK(MAX_SOCK), .BANK_DEPTH(BANK_DEPTH)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(dat_we), .sock(dec_sock), .loc(dec_loc),
      .wdata(host_wdata), .rdata(bank_byte));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_rdata <= '0;
         rd_stb     <= 1'b0;
         rd_sock    <= '0;
         rd_reg     <= '0;
      end else begin
         rd_stb <= dat_rd && dec_present;
         if (any_rd) begin
            if (host_addr == LOC_INDEX) host_rdata <= idx_q;
            else                        host_rdata <= dec_present ? bank_byte : '0;
         end
         if (dat_rd && dec_present) begin
            rd_sock <= dec_sock;
            rd_reg  <= dec_loc;
         end
      end
   end

   // R6: a strobe only follows a data-window read
   a_r6_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |-> $past(host_sel && !host_wr && host_addr));

   // R5: absent-bank reads return zero
   a_r5_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_rd && !dec_present) |=> (host_rdata == '0) && !rd_stb);

   // R10: read data holds when no read happens
   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !any_rd |=> $stable(host_rdata));

endmodule

// File: tb/sockport_top_tb_top.sv
module sockport_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       host_sel, host_wr, host_addr;
   logic [7:0] host_wdata, host_rdata;
   logic       cfg_we, cfg_target;
   logic [7:0] cfg_wdata, route_pci;
   logic [2:0] active_count;
   logic       rd_stb;
   logic [1:0] rd_sock;
   logic [5:0] rd_reg;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;  // 125 MHz

   sockport_top dut_i (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .cfg_we(cfg_we), .cfg_target(cfg_target), .cfg_wdata(cfg_wdata),
      .active_count(active_count), .route_pci(route_pci),
      .rd_stb(rd_stb), .rd_sock(rd_sock), .rd_reg(rd_reg));

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // all bus tasks start and end at a negedge
   task automatic idle;
      host_sel = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
      cfg_we = 0; cfg_target = 0; cfg_wdata = 0;
   endtask

   task automatic cycle;
      @(negedge clk);
      idle();
   endtask

   task automatic idx_wr(input logic [7:0] v);
      host_sel = 1; host_wr = 1; host_addr = 0; host_wdata = v;
      cycle();
   endtask

   task automatic dat_wr(input logic [7:0] v);
      host_sel = 1; host_wr = 1; host_addr = 1; host_wdata = v;
      cycle();
   endtask

   task automatic rd(input logic a, output logic [7:0] v);
      host_sel = 1; host_wr = 0; host_addr = a;
      cycle();
      v = host_rdata;
   endtask

   task automatic cfg_wr(input logic tgt, input logic [7:0] v);
      cfg_we = 1; cfg_target = tgt; cfg_wdata = v;
      cycle();
   endtask

   task automatic t_reset;
      logic [7:0] v;
      chk("R10", "rdata after reset", host_rdata, 8'h00);
      chk("R4", "count after reset", active_count, 2);
      chk("R7", "route after reset", route_pci, 8'h00);
      chk("R6", "no strobe after reset", rd_stb, 0);
      rd(0, v);
      chk("R1", "index after reset", v, 8'h00);
      rd(1, v);
      chk("R2", "reg 0 after reset", v, 8'h00);
   endtask

   task automatic t_index;
      logic [7:0] v;
      idx_wr(8'hA7);
      rd(0, v);
      chk("R1", "index readback", v, 8'hA7);
      idx_wr(8'h13);
      rd(0, v);
      chk("R1", "index readback 2", v, 8'h13);
   endtask

   task automatic t_banks;
      logic [7:0] v;
      cfg_wr(0, 8'h04);
      for (int s = 0; s < 4; s++) begin
         idx_wr(8'(s * 64 + 9));
         dat_wr(8'(8'h50 + s));
      end
      for (int s = 0; s < 4; s++) begin
         idx_wr(8'(s * 64 + 9));
         rd(1, v);
         chk("R2", $sformatf("bank %0d reg 9", s), v, 8'h50 + s);
      end
      idx_wr(8'h0A);
      rd(1, v);
      chk("R2", "neighbour reg untouched", v, 8'h00);
   endtask

   task automatic t_rmw;
      logic [7:0] v, i;
      idx_wr(8'h89);
      rd(1, v);
      rd(0, i);
      chk("R3", "index kept after data read", i, 8'h89);
      idx_wr(8'h89);
      dat_wr(v | 8'h08);
      rd(0, i);
      chk("R3", "index kept after data write", i, 8'h89);
      rd(1, v);
      chk("R3", "rmw result", v, 8'h5A);
      idx_wr(8'h49);
      rd(1, v);
      chk("R3", "other bank same reg untouched", v, 8'h51);
   endtask

   task automatic t_count;
      cfg_wr(0, 8'h00); chk("R4", "field 00", active_count, 2);
      cfg_wr(0, 8'h02); chk("R4", "field 01", active_count, 1);
      cfg_wr(0, 8'h04); chk("R4", "field 10", active_count, 4);
      cfg_wr(0, 8'h06); chk("R4", "field 11", active_count, 4);
      cfg_wr(0, 8'hF9); chk("R4", "other bits ignored", active_count, 2);
      chk("R7", "route unchanged by cfg", route_pci, 8'h00);
   endtask

   task automatic t_absent;
      logic [7:0] v;
      cfg_wr(0, 8'h04);
      idx_wr(8'h41); dat_wr(8'h33);
      cfg_wr(0, 8'h02);  // one socket
      dat_wr(8'h77);
      host_sel = 1; host_wr = 0; host_addr = 1;
      cycle();
      chk("R5", "absent read data", host_rdata, 8'h00);
      chk("R6", "absent read no strobe", rd_stb, 0);
      cfg_wr(0, 8'h04);
      rd(1, v);
      chk("R5", "absent write dropped", v, 8'h33);
   endtask

   task automatic t_strobe;
      logic [7:0] v;
      idx_wr(8'hC5);
      chk("R6", "no strobe on index write", rd_stb, 0);
      host_sel = 1; host_wr = 0; host_addr = 1;
      cycle();
      chk("R6", "strobe high", rd_stb, 1);
      chk("R6", "strobe socket", rd_sock, 3);
      chk("R6", "strobe reg", rd_reg, 5);
      cycle();
      chk("R6", "strobe one cycle", rd_stb, 0);
      chk("R10", "rdata held", host_rdata, 8'h00);
      dat_wr(8'h12);
      chk("R6", "no strobe on data write", rd_stb, 0);
      rd(0, v);
      chk("R6", "no strobe on index read", rd_stb, 0);
   endtask

   task automatic t_route;
      cfg_wr(1, 8'hFF);
      chk("R7", "route all PCI", route_pci, 8'hFF);
      cfg_wr(1, 8'h5C);
      chk("R7", "route mixed", route_pci, 8'h5C);
      cfg_wr(0, 8'h04);
      chk("R7", "route kept", route_pci, 8'h5C);
   endtask

   task automatic t_word16;
      logic [7:0] v;
      idx_wr(8'h90); dat_wr(8'h34);
      idx_wr(8'h91); dat_wr(8'h12);
      idx_wr(8'h90); dat_wr(8'hCD);
      idx_wr(8'h91); rd(1, v);
      chk("R8", "high half kept", v, 8'h12);
      idx_wr(8'h90); rd(1, v);
      chk("R8", "low half rewritten", v, 8'hCD);
   endtask

   task automatic t_same_cycle;
      logic [7:0] v;
      cfg_wr(0, 8'h04);
      idx_wr(8'h80);
      host_sel = 1; host_wr = 1; host_addr = 1; host_wdata = 8'h5A;
      cfg_we = 1; cfg_target = 0; cfg_wdata = 8'h00;  // 4 -> 2 sockets
      cycle();
      chk("R9", "count dropped", active_count, 2);
      host_sel = 1; host_wr = 1; host_addr = 1; host_wdata = 8'h11;
      cfg_we = 1; cfg_target = 0; cfg_wdata = 8'h04;  // 2 -> 4 sockets
      cycle();
      rd(1, v);
      chk("R9", "old count gates writes", v, 8'h5A);
   endtask

   initial begin
      idle();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_index();
      t_banks();
      t_rmw();
      t_count();
      t_absent();
      t_strobe();
      t_route();
      t_word16();
      t_same_cycle();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            fails++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule